// File: doc/BRIEF.md
# Machine Status Register Write Legalizer

This block holds the 32-bit machine status word of a small RISC-V style core and legalizes every write to it. A write arrives either through the machine view, where it offers a full word, or through the supervisor view, where only the supervisor-visible bits of the offered word are merged into the current value. In both cases the merged candidate then passes through the same machine-level legalization before it is stored. Only the machine-writable fields change. A previous-privilege value that names an unsupported mode is discarded for that field alone. The floating-point state field is collapsed to off or dirty. The summary-dirty bit is recomputed from the state fields.

Both views are readable at all times. The supervisor view is the stored word masked to its visible bits. When a committed write changes any field that affects address translation, the block raises a one-cycle flush request in the cycle after the commit. This pulse comes from a two-state controller: `FL_IDLE` moves to `FL_PULSE` on a committed write that changes a translation-related bit. `FL_PULSE` moves back to `FL_IDLE` when no such write follows, and stays in `FL_PULSE` when another one does. The flush request is high only in `FL_PULSE`.

Field positions: UIE=0, SIE=1, MIE=3, UPIE=4, SPIE=5, MPIE=7, SPP=8, MPP=12:11, FS=14:13, XS=16:15, MPRV=17, SUM=18, MXR=19 and SD=31. Privilege codes are user 0, supervisor 1, hypervisor 2 and machine 3.

Top module: `mstat_reg`

## Requirements
- R1: After reset, `mach_rd` is 0x00001800 (MPP = 3, every other bit 0), `sup_rd` is 0 and `xlat_flush` is 0.
- R2: A machine-view write changes only SIE, SPIE, MIE, MPIE, SPP, FS, MPRV, SUM, MPP and MXR (mask 0x000E79AA). Every other bit keeps its value, apart from SD, which is derived as in R6.
- R3: A written MPP of 2 leaves MPP unchanged, while the other fields of that write still take effect.
- R4: With `SUP_PRESENT`=0, a written MPP of 1 is discarded. With `USR_PRESENT`=0, a written MPP of 0 is discarded. In both cases the other fields are still written.
- R5: After legalization, any nonzero FS value is stored as 3, so FS only ever reads as 0 or 3.
- R6: SD (bit 31) is 1 exactly when FS is 3 or XS is 3, and it is recomputed on every write.
- R7: `xlat_flush` is high for the single cycle after a committed write whose result differs from the old value in MXR, MPP, MPRV or SUM. It stays low after writes that change none of these bits.
- R8: With `wr_sup_view`=1, only UIE, SIE, UPIE, SPIE, SPP, FS, XS, SUM, MXR and SD (mask 0x800DE133) are taken from `wr_data`. The merged word then goes through the legalization of R2 to R6, so MIE, MPIE, MPP and MPRV keep their values.
- R9: `sup_rd` always equals `mach_rd` ANDed with 0x800DE133.
- R10: A write commits on the rising edge where `wr_en` is high. With `wr_en` low the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Commit a write at this edge |
| wr_sup_view | input | 1 | 1: supervisor-view write, 0: machine-view write |
| wr_data | input | 32 | Offered write word |
| mach_rd | output | 32 | Machine view of the stored word |
| sup_rd | output | 32 | Supervisor view (stored word masked) |
| xlat_flush | output | 1 | Translation flush request pulse |

## Verification
Every write result is due one clock edge after the edge that commits it. The machine and supervisor reads change right after that edge, and the flush pulse rises at the same edge and falls one edge later. The bench changes inputs on falling edges. It reads both views and the flush output at the next falling edge, which is half a cycle after the commit. It then holds the write enable low for one more cycle and reads again, to confirm that the pulse has ended and that the stored word has not moved. A second instance, built without supervisor or user mode, covers the discarded previous-privilege values.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int XLEN = 32;

    typedef logic [XLEN-1:0] word_t;

    // field positions
    localparam int B_UIE  = 0;
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_UPIE = 4;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;
    localparam int B_FS   = 13;
    localparam int B_XS   = 15;
    localparam int B_MPRV = 17;
    localparam int B_SUM  = 18;
    localparam int B_MXR  = 19;
    localparam int B_SD   = XLEN - 1;

    localparam word_t ONE = word_t'(1);
    localparam word_t TWO_BITS = word_t'(3);

    localparam word_t F_MPP = TWO_BITS << B_MPP;
    localparam word_t F_FS  = TWO_BITS << B_FS;
    localparam word_t F_XS  = TWO_BITS << B_XS;

    // bits a machine-view write may change
    localparam word_t MACH_WMASK =
        (ONE << B_SIE) | (ONE << B_SPIE) | (ONE << B_MIE) | (ONE << B_MPIE) |
        (ONE << B_SPP) | F_FS | (ONE << B_MPRV) | (ONE << B_SUM) | F_MPP |
        (ONE << B_MXR);

    // bits visible / writable through the supervisor view
    localparam word_t SUP_MASK =
        (ONE << B_UIE) | (ONE << B_SIE) | (ONE << B_UPIE) | (ONE << B_SPIE) |
        (ONE << B_SPP) | F_FS | F_XS | (ONE << B_SUM) | (ONE << B_MXR) |
        (ONE << B_SD);

    // bits whose change requests a translation flush
    localparam word_t XLAT_MASK =
        (ONE << B_MXR) | F_MPP | (ONE << B_MPRV) | (ONE << B_SUM);

    typedef enum logic [1:0] {
        PRIV_USR = 2'd0,
        PRIV_SUP = 2'd1,
        PRIV_HYP = 2'd2,
        PRIV_MCH = 2'd3
    } priv_t;

    localparam word_t RESET_WORD = word_t'(PRIV_MCH) << B_MPP;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_PULSE = 1'b1
    } fl_state_t;

endpackage

// File: rtl/mstat_view_merge.sv
module mstat_view_merge
    import mstat_pkg::*;
(
    input  word_t old_word,
    input  word_t wr_data,
    input  logic  sup_view,
    output word_t cand,
    output word_t sup_word
);

    // supervisor view replaces only its visible bits; machine view offers all
    always_comb begin
        if (sup_view) begin
            cand = (old_word & ~SUP_MASK) | (wr_data & SUP_MASK);
        end else begin
            cand = wr_data;
        end
    end

    assign sup_word = old_word & SUP_MASK;

endmodule

// File: rtl/mstat_legalize.sv
module mstat_legalize
    import mstat_pkg::*;
#(
    parameter bit SUP_PRESENT = 1'b1,
    parameter bit USR_PRESENT = 1'b1
) (
    input  word_t old_word,
    input  word_t cand,
    output word_t new_word,
    output logic  xlat_diff
);

    // legal previous-privilege codes, indexed by code
    localparam logic [3:0] MPP_LEGAL = {1'b1, 1'b0, SUP_PRESENT, USR_PRESENT};

    logic [1:0] mpp_req;
    logic       mpp_ok;
    word_t      wmask;
    word_t      merged;
    word_t      fixed;

    assign mpp_req = cand[B_MPP +: 2];
    assign mpp_ok  = MPP_LEGAL[mpp_req];
    assign wmask   = mpp_ok ? MACH_WMASK : (MACH_WMASK & ~F_MPP);
    assign merged  = (old_word & ~wmask) | (cand & wmask);

    always_comb begin
        fixed = merged;
        if (fixed[B_FS +: 2] != 2'b00) begin
            fixed[B_FS +: 2] = 2'b11;
        end
        fixed[B_SD] = (fixed[B_FS +: 2] == 2'b11) || (fixed[B_XS +: 2] == 2'b11);
    end

    assign new_word  = fixed;
    assign xlat_diff = |((fixed ^ old_word) & XLAT_MASK);

endmodule

// File: rtl/mstat_flush_fsm.sv
module mstat_flush_fsm
    import mstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic xlat_diff,
    output logic flush
);

    fl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  state_d = (commit && xlat_diff) ? FL_PULSE : FL_IDLE;
            FL_PULSE: state_d = (commit && xlat_diff) ? FL_PULSE : FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_PULSE: flush = 1'b1;
            default:  flush = 1'b0;
        endcase
    end

    // R7: a pulse is always preceded by a committing write
    p_pulse_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(commit));

    // R7: pulse ends unless a new changing write arrives
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && xlat_diff) |=> !flush);

endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
    import mstat_pkg::*;
#(
    parameter bit SUP_PRESENT = 1'b1,
    parameter bit USR_PRESENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sup_view,
    input  logic [31:0] wr_data,
    output logic [31:0] mach_rd,
    output logic [31:0] sup_rd,
    output logic        xlat_flush
);

    word_t stat_q;
    word_t cand;
    word_t new_word;
    word_t sup_word;
    logic  xlat_diff;

    mstat_view_merge u_merge (
        .old_word (stat_q),
        .wr_data  (wr_data),
        .sup_view (wr_sup_view),
        .cand     (cand),
        .sup_word (sup_word)
    );

    mstat_legalize #(
        .SUP_PRESENT (SUP_PRESENT),
        .USR_PRESENT (USR_PRESENT)
    ) u_legal (
        .old_word  (stat_q),
        .cand      (cand),
        .new_word  (new_word),
        .xlat_diff (xlat_diff)
    );

    mstat_flush_fsm u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (wr_en),
        .xlat_diff (xlat_diff),
        .flush     (xlat_flush)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RESET_WORD;
        end else if (wr_en) begin
            stat_q <= new_word;
        end
    end

    assign mach_rd = stat_q;
    assign sup_rd  = sup_word;

    // R5: stored FS is only off or dirty
    p_fs_collapsed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[B_FS +: 2] == 2'b00) || (stat_q[B_FS +: 2] == 2'b11));

    // R6: summary bit tracks the state fields
    p_sd_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[B_SD] == ((stat_q[B_FS +: 2] == 2'b11) || (stat_q[B_XS +: 2] == 2'b11)));

    // R3: hypervisor code is never stored
    p_mpp_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[B_MPP +: 2] != 2'b10);

    // R2: bits outside the writable set and SD stay zero
    p_ro_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~(MACH_WMASK | (ONE << B_SD))) == '0);

    // R10: no write enable, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stat_q));

    // R8: supervisor write leaves machine-only fields alone
    p_sup_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sup_view) |=>
            ((stat_q & (F_MPP | (ONE << B_MIE) | (ONE << B_MPIE) | (ONE << B_MPRV)))
             == $past(stat_q & (F_MPP | (ONE << B_MIE) | (ONE << B_MPIE) | (ONE << B_MPRV)))));

endmodule

// File: tb/tb_mstat_reg.sv
`timescale 1ns/1ps
module tb_mstat_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sup_view = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mach_rd, sup_rd;
    logic        xlat_flush;

    logic        b_wr_en = 1'b0;
    logic [31:0] b_wr_data = '0;
    logic [31:0] b_mach_rd, b_sup_rd;
    logic        b_flush;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] SUPV = 32'h800DE133;

    always #4 clk = ~clk;

    mstat_reg dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sup_view (wr_sup_view),
        .wr_data (wr_data), .mach_rd (mach_rd), .sup_rd (sup_rd),
        .xlat_flush (xlat_flush)
    );

    mstat_reg #(.SUP_PRESENT (1'b0), .USR_PRESENT (1'b0)) dut_mo (
        .clk (clk), .rst_n (rst_n), .wr_en (b_wr_en), .wr_sup_view (1'b0),
        .wr_data (b_wr_data), .mach_rd (b_mach_rd), .sup_rd (b_sup_rd),
        .xlat_flush (b_flush)
    );

    // {sup_view, data, expected machine word, expected flush}
    localparam int NV = 10;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'hFFFFFFFF, 32'h800E79AA, 1'b1},
        {1'b0, 32'h00000000, 32'h00000000, 1'b1},
        {1'b0, 32'h00002000, 32'h80006000, 1'b0},
        {1'b0, 32'h0000100A, 32'h0000000A, 1'b0},
        {1'b0, 32'h00000800, 32'h00000800, 1'b1},
        {1'b0, 32'h00001008, 32'h00000808, 1'b0},
        {1'b1, 32'hFFFFFFFF, 32'h800C692A, 1'b1},
        {1'b1, 32'h00000000, 32'h00000808, 1'b1},
        {1'b0, 32'h00000808, 32'h00000808, 1'b0},
        {1'b0, 32'h00020808, 32'h00020808, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mach", mach_rd, 32'h00001800);
        chk("R1 sup", sup_rd, 32'h0);
        chk("R1 flush", {31'b0, xlat_flush}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mach after release", mach_rd, 32'h00001800);

        for (int i = 0; i < NV; i++) begin
            wr_sup_view = VEC[i][65];
            wr_data     = VEC[i][64:33];
            wr_en       = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            // R2/R3/R5/R6/R8 machine word, R9 supervisor view, R7 pulse
            chk($sformatf("R2/R3/R5/R6/R8 vec%0d mach", i), mach_rd, VEC[i][32:1]);
            chk($sformatf("R9 vec%0d sup", i), sup_rd, VEC[i][32:1] & SUPV);
            chk($sformatf("R7 vec%0d flush", i), {31'b0, xlat_flush}, {31'b0, VEC[i][0]});
            @(negedge clk);
            chk($sformatf("R7 vec%0d pulse end", i), {31'b0, xlat_flush}, 32'h0);
            chk($sformatf("R10 vec%0d hold", i), mach_rd, VEC[i][32:1]);
        end

        // R10: data change with enable low has no effect
        wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R10 idle data ignored", mach_rd, 32'h00020808);
        chk("R10 idle no flush", {31'b0, xlat_flush}, 32'h0);

        // R7 back-to-back changing writes keep pulse high
        wr_sup_view = 1'b0;
        wr_data = 32'h00040000;
        wr_en = 1'b1;
        @(negedge clk);
        wr_data = 32'h00080000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 back-to-back flush", {31'b0, xlat_flush}, 32'h1);
        chk("R7 back-to-back mach", mach_rd, 32'h00080000);
        @(negedge clk);
        chk("R7 back-to-back end", {31'b0, xlat_flush}, 32'h0);

        // R4: no supervisor / user mode instance
        chk("R4 reset", b_mach_rd, 32'h00001800);
        b_wr_data = 32'h00000808;
        b_wr_en = 1'b1;
        @(negedge clk);
        b_wr_en = 1'b0;
        chk("R4 mpp1 dropped", b_mach_rd, 32'h00001808);
        chk("R4 no flush", {31'b0, b_flush}, 32'h0);
        b_wr_data = 32'h00000080;
        b_wr_en = 1'b1;
        @(negedge clk);
        b_wr_en = 1'b0;
        chk("R4 mpp0 dropped", b_mach_rd, 32'h00001880);
        b_wr_data = 32'h00001800;
        b_wr_en = 1'b1;
        @(negedge clk);
        b_wr_en = 1'b0;
        chk("R4 mpp3 kept", b_mach_rd, 32'h00001800);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule